// File: doc/BRIEF.md
# Single-Buffer Host DMA Channel

This block is the bus-master data mover that sits behind the data FIFO of a card host controller. Software loads one contiguous buffer description and then triggers the channel. The description has a direction, an address mode and a 64-bit start address split into two 32-bit halves. The channel then moves 32-bit words, one request at a time, between the FIFO streams and system memory until the programmed length is exhausted. It reports the outcome in two small status words: completion and error, each with a separate bit per direction.

Software reaches the channel through a plain write port: a write strobe, a 3-bit register selector and 32 bits of data. The transfer length is not held here. It is taken from the host's block-size and block-count inputs at the moment the channel starts. A path-select bit decides whether the FIFO is served by this channel or by programmed I/O. While that bit is low the channel refuses to start. The current value of the bit is driven out on `dma_path`.

All data interfaces use valid/ready. A beat transfers on a rising edge where both valid and ready are high. The memory request and the card-bound FIFO output hold valid and payload steady until ready is seen, so back-pressure may last any number of cycles. Only one memory request is ever outstanding. Responses are always accepted.

Top module: `dmac_channel`

## Requirements
- R1: After reset, `busy`, `req_valid`, `fout_valid` and `fin_ready` are low, both status words are zero and `dma_path` is low.
- R2: Register selectors are 0 mode, 1 control, 2 channel reset, 3 completion status, 4 error status, 5 address low, 6 address high and 7 path select. Path-select bit 1 drives `dma_path`. Writing control bit 0 is a one-shot start and stores nothing. A start is ignored unless `dma_path` is high and the channel is idle.
- R3: With mode bit 16 set, the channel moves data toward memory. It takes each word from `fin` and writes it to memory in arrival order. After the last write response it sets completion bit 20.
- R4: With mode bit 16 clear, the channel moves data toward the card. It reads each word from memory and presents it on `fout` in order, holding it until `fout_ready`. After the last word is taken it sets completion bit 16.
- R5: The start address is {address high, address low}. With mode bit 0 set, the address rises by 4 after each word. With mode bit 0 clear, every request uses the start address.
- R6: The word count is ceil(block size × block count / 4), sampled at start. A start with a zero count sets the direction's completion bit at once and issues no request.
- R7: A start whose address has any of bits 3:0 set issues no request and leaves the channel idle. It sets error bit 17 for toward-memory or error bit 16 for toward-card.
- R8: A memory response with `rsp_err` high ends the transfer. It sets the direction's error bit (17 toward memory, 16 toward card) and no completion bit.
- R9: A write to a status word keeps only the bits that are written as 1. Writing zero clears that word.
- R10: Channel-reset bit 9 aborts an active toward-memory transfer and bit 8 aborts an active toward-card transfer. In both cases no status bit is set. A reset bit for the other direction has no effect.
- R11: `req_valid`, `req_addr`, `req_write` and `req_wdata` stay stable until `req_ready`. No new request is issued before the previous response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | 32 | Register write data |
| blk_size | input | 16 | Host block size in bytes |
| blk_count | input | 16 | Host block count |
| dma_path | output | 1 | FIFO served by this channel (1) or programmed I/O (0) |
| busy | output | 1 | Transfer in progress |
| stat_done | output | 32 | Completion status word |
| stat_err | output | 32 | Error status word |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | Request is a write |
| req_addr | output | 64 | Request byte address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Memory response valid |
| rsp_err | input | 1 | Response carries a bus error |
| rsp_rdata | input | 32 | Read data |
| fin_valid | input | 1 | FIFO word available toward memory |
| fin_ready | output | 1 | Channel takes the FIFO word |
| fin_data | input | 32 | FIFO word toward memory |
| fout_valid | output | 1 | Word available toward the card |
| fout_ready | input | 1 | Card-side FIFO accepts the word |
| fout_data | output | 32 | Word toward the card |

## Verification
The assertions assume the memory side returns exactly one response for each accepted request, and never returns a response while nothing is outstanding. They also assume a channel reset is the only way a held `req_valid` or `fout_valid` may be withdrawn. The bench's memory model answers every accepted request on the next cycle and only then. In the one abort scenario, the channel is stalled on an empty `fin` stream, so no request is outstanding when the reset is written. Back-pressure on `fout` follows a repeating ready pattern, so held-word stability is exercised across several stalls per transfer.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [2:0] SEL_MODE  = 3'd0;
  localparam logic [2:0] SEL_CTRL  = 3'd1;
  localparam logic [2:0] SEL_CRST  = 3'd2;
  localparam logic [2:0] SEL_DONE  = 3'd3;
  localparam logic [2:0] SEL_ERR   = 3'd4;
  localparam logic [2:0] SEL_ALO   = 3'd5;
  localparam logic [2:0] SEL_AHI   = 3'd6;
  localparam logic [2:0] SEL_PATH  = 3'd7;

  localparam int B_DIR        = 16;
  localparam int B_INC        = 0;
  localparam int B_START      = 0;
  localparam int B_PATH       = 1;
  localparam int B_RST_TOMEM  = 9;
  localparam int B_RST_TOCARD = 8;
  localparam int B_DONE_TOMEM = 20;
  localparam int B_DONE_TOCRD = 16;
  localparam int B_ERR_TOMEM  = 17;
  localparam int B_ERR_TOCRD  = 16;

  // index 1 = toward memory, index 0 = toward card
  typedef enum logic [2:0] {
    ST_IDLE, ST_PULL, ST_WREQ, ST_WRSP, ST_RREQ, ST_RRSP, ST_PUSH
  } chan_state_e;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [1:0]        done_set,
  input  logic [1:0]        err_set,
  output logic              mode_dir,
  output logic              mode_inc,
  output logic              path_en,
  output logic [ADDR_W-1:0] base_addr,
  output logic              start_req,
  output logic              rst_tomem,
  output logic              rst_tocard,
  output logic [REG_W-1:0]  stat_done,
  output logic [REG_W-1:0]  stat_err
);
  logic [REG_W-1:0] alo_q, ahi_q;
  logic [1:0] done_q, err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_dir <= 1'b0;
      mode_inc <= 1'b0;
      path_en  <= 1'b0;
      alo_q    <= '0;
      ahi_q    <= '0;
      done_q   <= '0;
      err_q    <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_MODE) begin
        mode_dir <= reg_wdata[B_DIR];
        mode_inc <= reg_wdata[B_INC];
      end
      if (reg_we && reg_sel == SEL_PATH) path_en <= reg_wdata[B_PATH];
      if (reg_we && reg_sel == SEL_ALO)  alo_q <= reg_wdata;
      if (reg_we && reg_sel == SEL_AHI)  ahi_q <= reg_wdata;
      if (reg_we && reg_sel == SEL_DONE)
        done_q <= (done_q & {reg_wdata[B_DONE_TOMEM], reg_wdata[B_DONE_TOCRD]}) | done_set;
      else
        done_q <= done_q | done_set;
      if (reg_we && reg_sel == SEL_ERR)
        err_q <= (err_q & {reg_wdata[B_ERR_TOMEM], reg_wdata[B_ERR_TOCRD]}) | err_set;
      else
        err_q <= err_q | err_set;
    end
  end

  assign base_addr  = ADDR_W'({ahi_q, alo_q});
  assign start_req  = reg_we && reg_sel == SEL_CTRL && reg_wdata[B_START];
  assign rst_tomem  = reg_we && reg_sel == SEL_CRST && reg_wdata[B_RST_TOMEM];
  assign rst_tocard = reg_we && reg_sel == SEL_CRST && reg_wdata[B_RST_TOCARD];

  always_comb begin
    stat_done = '0;
    stat_err  = '0;
    stat_done[B_DONE_TOMEM] = done_q[1];
    stat_done[B_DONE_TOCRD] = done_q[0];
    stat_err[B_ERR_TOMEM]   = err_q[1];
    stat_err[B_ERR_TOCRD]   = err_q[0];
  end

  AST_CLEAR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_sel == SEL_DONE && reg_wdata == '0 && done_set == '0 |=> stat_done == '0); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err[B_ERR_TOMEM] && !(reg_we && reg_sel == SEL_ERR) |=> stat_err[B_ERR_TOMEM]); // R9
endmodule

// File: rtl/dmac_addr_gen.sv
module dmac_addr_gen #(
  parameter int ADDR_W     = 64,
  parameter int CNT_W      = 33,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              inc_in,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  words,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last
);
  logic [CNT_W-1:0] left_q;
  logic inc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      left_q   <= '0;
      inc_q    <= 1'b0;
    end else if (load) begin
      cur_addr <= base;
      left_q   <= words;
      inc_q    <= inc_in;
    end else if (step) begin
      if (inc_q) cur_addr <= cur_addr + ADDR_W'(WORD_BYTES);
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign last = (left_q == CNT_W'(1));
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int DATA_W      = 32,
  parameter int SIZE_W      = 16,
  parameter int COUNT_W     = 16,
  parameter int ALIGN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              path_en,
  input  logic              mode_dir,
  input  logic              mode_inc,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [SIZE_W-1:0] blk_size,
  input  logic [COUNT_W-1:0] blk_count,
  input  logic              rst_tomem,
  input  logic              rst_tocard,
  output logic              busy,
  output logic [1:0]        done_set,
  output logic [1:0]        err_set,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              fin_valid,
  output logic              fin_ready,
  input  logic [DATA_W-1:0] fin_data,
  output logic              fout_valid,
  input  logic              fout_ready,
  output logic [DATA_W-1:0] fout_data
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WB_BITS    = $clog2(WORD_BYTES);
  localparam int ALIGN_BITS = $clog2(ALIGN_BYTES);
  localparam int LEN_W      = SIZE_W + COUNT_W;
  localparam int WCNT_W     = LEN_W + 1;

  chan_state_e st_q, st_n;
  logic dir_q;
  logic [DATA_W-1:0] buf_q;
  logic [LEN_W-1:0] len_bytes;
  logic [WCNT_W-1:0] words;
  logic start_ok, misalign, abort, load, step, last;

  assign len_bytes = LEN_W'(blk_size) * LEN_W'(blk_count);
  assign words     = ({1'b0, len_bytes} + WCNT_W'(WORD_BYTES - 1)) >> WB_BITS;
  assign start_ok  = start_req && path_en && st_q == ST_IDLE;
  assign misalign  = |base_addr[ALIGN_BITS-1:0];
  assign abort     = st_q != ST_IDLE && ((dir_q && rst_tomem) || (!dir_q && rst_tocard));
  assign load      = start_ok && !misalign && words != '0;

  dmac_addr_gen #(
    .ADDR_W(ADDR_W), .CNT_W(WCNT_W), .WORD_BYTES(WORD_BYTES)
  ) u_agen (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .inc_in(mode_inc),
    .base(base_addr), .words(words), .cur_addr(req_addr), .last(last)
  );

  always_comb begin
    st_n     = st_q;
    step     = 1'b0;
    done_set = '0;
    err_set  = '0;
    unique case (st_q)
      ST_IDLE: if (start_ok) begin
        if (misalign)          err_set[mode_dir]  = 1'b1;
        else if (words == '0)  done_set[mode_dir] = 1'b1;
        else                   st_n = mode_dir ? ST_PULL : ST_RREQ;
      end
      ST_PULL: if (fin_valid) st_n = ST_WREQ;
      ST_WREQ: if (req_ready) st_n = ST_WRSP;
      ST_WRSP: if (rsp_valid) begin
        if (rsp_err)   begin err_set[1] = 1'b1;  st_n = ST_IDLE; end
        else if (last) begin done_set[1] = 1'b1; st_n = ST_IDLE; end
        else           begin step = 1'b1;        st_n = ST_PULL; end
      end
      ST_RREQ: if (req_ready) st_n = ST_RRSP;
      ST_RRSP: if (rsp_valid) begin
        if (rsp_err) begin err_set[0] = 1'b1; st_n = ST_IDLE; end
        else         st_n = ST_PUSH;
      end
      ST_PUSH: if (fout_ready) begin
        if (last) begin done_set[0] = 1'b1; st_n = ST_IDLE; end
        else      begin step = 1'b1;        st_n = ST_RREQ; end
      end
      default: st_n = ST_IDLE;
    endcase
    if (abort) begin
      st_n     = ST_IDLE;
      step     = 1'b0;
      done_set = '0;
      err_set  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dir_q <= 1'b0;
      buf_q <= '0;
    end else begin
      st_q <= st_n;
      if (load) dir_q <= mode_dir;
      if (st_q == ST_PULL && fin_valid) buf_q <= fin_data;
      else if (st_q == ST_RRSP && rsp_valid) buf_q <= rsp_rdata;
    end
  end

  assign busy       = st_q != ST_IDLE;
  assign fin_ready  = st_q == ST_PULL;
  assign req_valid  = st_q == ST_WREQ || st_q == ST_RREQ;
  assign req_write  = st_q == ST_WREQ;
  assign req_wdata  = buf_q;
  assign fout_valid = st_q == ST_PUSH;
  assign fout_data  = buf_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !abort |=> req_valid && $stable(req_addr)
      && $stable(req_write) && $stable(req_wdata)); // R11
  AST_FOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fout_valid && !fout_ready && !abort |=> fout_valid && $stable(fout_data)); // R4
  AST_MISALIGN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && misalign |=> !busy && !req_valid); // R7
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fin_ready, req_valid, fout_valid})); // R11
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> done_set == '0 && err_set == '0); // R10
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int DATA_W      = 32,
  parameter int REG_W       = 32,
  parameter int SIZE_W      = 16,
  parameter int COUNT_W     = 16,
  parameter int ALIGN_BYTES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [SIZE_W-1:0]  blk_size,
  input  logic [COUNT_W-1:0] blk_count,
  output logic               dma_path,
  output logic               busy,
  output logic [REG_W-1:0]   stat_done,
  output logic [REG_W-1:0]   stat_err,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_write,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_wdata,
  input  logic               rsp_valid,
  input  logic               rsp_err,
  input  logic [DATA_W-1:0]  rsp_rdata,
  input  logic               fin_valid,
  output logic               fin_ready,
  input  logic [DATA_W-1:0]  fin_data,
  output logic               fout_valid,
  input  logic               fout_ready,
  output logic [DATA_W-1:0]  fout_data
);
  logic mode_dir, mode_inc, start_req, rst_tomem, rst_tocard;
  logic [ADDR_W-1:0] base_addr;
  logic [1:0] done_set, err_set;

  dmac_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .done_set(done_set), .err_set(err_set),
    .mode_dir(mode_dir), .mode_inc(mode_inc), .path_en(dma_path),
    .base_addr(base_addr), .start_req(start_req), .rst_tomem(rst_tomem),
    .rst_tocard(rst_tocard), .stat_done(stat_done), .stat_err(stat_err)
  );

  dmac_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
    .COUNT_W(COUNT_W), .ALIGN_BYTES(ALIGN_BYTES)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .path_en(dma_path),
    .mode_dir(mode_dir), .mode_inc(mode_inc), .base_addr(base_addr),
    .blk_size(blk_size), .blk_count(blk_count), .rst_tomem(rst_tomem),
    .rst_tocard(rst_tocard), .busy(busy), .done_set(done_set), .err_set(err_set),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .fin_valid(fin_valid),
    .fin_ready(fin_ready), .fin_data(fin_data), .fout_valid(fout_valid),
    .fout_ready(fout_ready), .fout_data(fout_data)
  );

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !fout_valid && !fin_ready); // R11
  AST_STATUS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_set != '0 || err_set != '0) |=> !busy); // R8
endmodule

// File: tb/dmac_channel_test.sv
module dmac_channel_test;
  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [2:0] reg_sel;
  logic [31:0] reg_wdata;
  logic [15:0] blk_size, blk_count;
  logic dma_path, busy;
  logic [31:0] stat_done, stat_err;
  logic req_valid, req_ready, req_write;
  logic [63:0] req_addr;
  logic [31:0] req_wdata;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic fin_valid, fin_ready;
  logic [31:0] fin_data;
  logic fout_valid, fout_ready;
  logic [31:0] fout_data;

  always #2 clk = ~clk;

  dmac_channel uut (.*);

  typedef struct packed {
    logic        dir;
    logic        inc;
    logic [31:0] alo;
    logic [15:0] size;
    logic [15:0] cnt;
    logic [7:0]  err_at;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 1'b1, 32'h0000_0100, 16'd16, 16'd2, 8'd0},
    '{1'b0, 1'b1, 32'h0000_2000, 16'd8,  16'd3, 8'd0},
    '{1'b1, 1'b0, 32'h0000_0340, 16'd12, 16'd1, 8'd0},
    '{1'b0, 1'b0, 32'h0000_0050, 16'd4,  16'd1, 8'd0},
    '{1'b1, 1'b1, 32'h0000_0400, 16'd16, 16'd1, 8'd2},
    '{1'b0, 1'b1, 32'h0000_0600, 16'd16, 16'd1, 8'd3}
  };
  localparam logic [31:0] AHI = 32'h0000_0001;
  localparam logic [31:0] FIN_BASE = 32'hF00D_0000;

  int tests = 0, fails = 0;
  int reqs, pushes, fin_cnt, cyc;
  logic pend, pend_err;
  logic [31:0] pend_data;
  logic cur_inc;
  logic [31:0] cur_alo;
  int cur_err_at;

  function automatic logic [31:0] rd_pat(input logic [63:0] a);
    return a[31:0] ^ 32'hC0DE_0000 ^ {a[35:32], 28'h0};
  endfunction

  function automatic logic [63:0] exp_addr(input int beat);
    return {AHI, cur_alo} + (cur_inc ? 64'(beat) * 64'd4 : 64'd0);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input logic dir, input logic inc, input logic [31:0] alo,
                       input logic [15:0] sz, input logic [15:0] cn, input int err_at);
    cur_inc = inc; cur_alo = alo; cur_err_at = err_at;
    reqs = 0; pushes = 0; fin_cnt = 0; pend = 1'b0;
    blk_size = sz; blk_count = cn;
    wr(3'd0, (32'(dir) << 16) | 32'(inc));
    wr(3'd5, alo);
    wr(3'd6, AHI);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h0);
  endtask

  // called at a negedge; services the memory model and streams until idle
  task automatic run(input int limit);
    for (int i = 0; i < limit; i++) begin
      rsp_valid = 1'b0; rsp_err = 1'b0;
      if (!busy) break;
      cyc++;
      if (pend) begin
        rsp_valid = 1'b1; rsp_rdata = pend_data; rsp_err = pend_err; pend = 1'b0;
      end
      if (req_valid) begin
        check(req_addr == exp_addr(reqs), "R5", "request address", req_addr, exp_addr(reqs));
        if (req_write)
          check(req_wdata == FIN_BASE + 32'(reqs), "R3", "write data",
                64'(req_wdata), 64'(FIN_BASE + 32'(reqs)));
        pend = 1'b1; pend_data = rd_pat(req_addr);
        pend_err = (reqs + 1 == cur_err_at);
        reqs++;
      end
      fin_data = FIN_BASE + 32'(fin_cnt);
      if (fin_ready && fin_valid) fin_cnt++;
      fout_ready = (cyc % 3) != 2;
      if (fout_valid && fout_ready) begin
        check(fout_data == rd_pat(exp_addr(pushes)), "R4", "card-bound data",
              64'(fout_data), 64'(rd_pat(exp_addr(pushes))));
        pushes++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    blk_size = '0; blk_count = '0; req_ready = 1'b1;
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
    fin_valid = 1'b1; fin_data = '0; fout_ready = 1'b1; cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!busy && !req_valid && !fout_valid && !fin_ready, "R1", "idle outputs",
          {busy, req_valid, fout_valid, fin_ready}, 0);
    check(stat_done == 0 && stat_err == 0, "R1", "status words",
          {stat_done, stat_err}, 0);
    check(!dma_path, "R1", "path select", dma_path, 0);

    // R2 start ignored while programmed I/O path selected
    setup(1'b1, 1'b1, 32'h100, 16'd16, 16'd1, 0);
    wr(3'd1, 32'h1);
    run(50);
    check(!busy && reqs == 0 && stat_done == 0, "R2", "start with path off",
          {busy, 32'(reqs)}, 0);
    wr(3'd7, 32'h2);
    check(dma_path, "R2", "path select bit 1", dma_path, 1);

    // table walk: R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      int words, exp_reqs, exp_push;
      logic [31:0] ed, ee;
      words = (int'(VECS[v].size) * int'(VECS[v].cnt) + 3) / 4;
      setup(VECS[v].dir, VECS[v].inc, VECS[v].alo, VECS[v].size, VECS[v].cnt,
            int'(VECS[v].err_at));
      wr(3'd1, 32'h1);
      run(2000);
      if (VECS[v].err_at == 0) begin
        exp_reqs = words;
        exp_push = VECS[v].dir ? 0 : words;
        ed = VECS[v].dir ? 32'h0010_0000 : 32'h0001_0000;
        ee = 0;
      end else begin
        exp_reqs = int'(VECS[v].err_at);
        exp_push = VECS[v].dir ? 0 : int'(VECS[v].err_at) - 1;
        ed = 0;
        ee = VECS[v].dir ? 32'h0002_0000 : 32'h0001_0000;
      end
      check(!busy, "R6", "channel idle after transfer", busy, 0);
      check(reqs == exp_reqs, "R6", "request count", reqs, exp_reqs);
      check(pushes == exp_push, "R4", "card-bound word count", pushes, exp_push);
      check(stat_done == ed, VECS[v].err_at != 0 ? "R8" : (VECS[v].dir ? "R3" : "R4"),
            "completion word", stat_done, ed);
      check(stat_err == ee, "R8", "error word", stat_err, ee);
    end

    // R7 misaligned start, both directions
    setup(1'b1, 1'b1, 32'h108, 16'd16, 16'd1, 0);
    wr(3'd1, 32'h1);
    run(50);
    check(reqs == 0 && stat_err == 32'h0002_0000 && stat_done == 0, "R7",
          "misaligned toward memory", stat_err, 32'h0002_0000);
    setup(1'b0, 1'b1, 32'h204, 16'd16, 16'd1, 0);
    wr(3'd1, 32'h1);
    run(50);
    check(reqs == 0 && stat_err == 32'h0001_0000, "R7",
          "misaligned toward card", stat_err, 32'h0001_0000);

    // R6 zero length
    setup(1'b1, 1'b1, 32'h100, 16'd0, 16'd4, 0);
    wr(3'd1, 32'h1);
    run(50);
    check(reqs == 0 && !busy && stat_done == 32'h0010_0000, "R6", "zero length",
          stat_done, 32'h0010_0000);

    // R9 write-to-clear keeps bits written as 1
    wr(3'd3, 32'h0010_0000);
    check(stat_done == 32'h0010_0000, "R9", "keep bit written 1", stat_done, 32'h0010_0000);
    wr(3'd3, 32'h0001_0000);
    check(stat_done == 0, "R9", "clear bit written 0", stat_done, 0);
    setup(1'b1, 1'b1, 32'h10C, 16'd4, 16'd1, 0);
    wr(3'd1, 32'h1);
    wr(3'd4, 32'h0);
    check(stat_err == 0, "R9", "error word cleared by zero", stat_err, 0);

    // R10 per-direction channel reset on a stalled toward-memory transfer
    fin_valid = 1'b0;
    setup(1'b1, 1'b1, 32'h800, 16'd16, 16'd1, 0);
    wr(3'd1, 32'h1);
    repeat (4) @(negedge clk);
    check(busy && fin_ready, "R10", "stalled on empty stream", busy, 1);
    wr(3'd2, 32'h0000_0100);
    check(busy, "R10", "other-direction reset ignored", busy, 1);
    wr(3'd2, 32'h0000_0200);
    check(!busy && !fin_ready && stat_done == 0 && stat_err == 0, "R10",
          "abort leaves no status", {busy, stat_done, stat_err}, 0);
    check(reqs == 0, "R10", "no request after abort", reqs, 0);
    fin_valid = 1'b1;

    // R2 start bit does not persist: a second transfer runs normally
    setup(1'b0, 1'b1, 32'h900, 16'd8, 16'd1, 0);
    wr(3'd1, 32'h1);
    run(500);
    check(reqs == 2 && stat_done == 32'h0001_0000, "R2", "restart after abort",
          stat_done, 32'h0001_0000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule